// File: doc/BRIEF.md
# Channel Event Flag Status Register

This block collects event flags from eight timer channels into one register that software can read with a single access. Each channel signals an event with a one-cycle pulse, which latches that channel's flag. The register sits at offset 0x50 of the timer's address window. It is reached over a simple bus with an address, a read strobe, a write strobe and 32-bit read and write data.

A flag cannot be dropped by a single write. Software must first read the register while the flag is set, which arms that bit. A later write of 0 to the bit then clears it. Any write to the register disarms every bit, and so does a fresh event on the channel. As a result, an event that lands between the read and the write survives the write, and its interrupt request is not lost. Each channel also drives an interrupt request, which is its flag gated by a per-channel enable input.

Top module: `chan_flag_status`

## Requirements
- R1: After reset every flag is 0, every interrupt request is 0, and a read of the register returns 0.
- R2: An event pulse on channel n sets flag n from the next clock cycle on.
- R3: A read strobe at offset 0x50 returns, in the same cycle, flag n in read-data bit n for n from 0 to 7, with bits 31 to 8 at 0.
- R4: A write of 0 to bit n clears flag n in the next cycle, provided an earlier read saw flag n as 1 and there has been no write and no event on channel n since that read.
- R5: Writing 1 to a flag bit leaves that flag unchanged.
- R6: A write of 0 to a bit that is not armed leaves the flag unchanged. This covers a bit with no prior read that saw it set, and a bit whose arming was used up by an earlier write.
- R7: An event on channel n after the arming read and before the clearing write keeps flag n set through that write.
- R8: An event on channel n in the same cycle as a clearing write leaves flag n set.
- R9: Interrupt request n equals flag n ANDed with enable input n, in every cycle.
- R10: Reads and writes at any offset other than 0x50 return 0 and change neither the flags nor the arming.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the strobe cycle |
| chan_event | input | NUM_CH | One-cycle event pulse per channel |
| irq_en | input | NUM_CH | Per-channel interrupt enable |
| irq_req | output | NUM_CH | Per-channel interrupt request |

## Verification
The bench targets the three ways the handshake can go wrong. The first is a zero write with no arming read; a design that skipped the arming would clear the flag. The second is an event between the arming read and the write; a design that failed to disarm would lose the flag. The third is an event in the same cycle as the clearing write; a design that gave the write priority would drop that interrupt. It also checks that ones in write data, a second zero write after the first, and accesses to a different offset have no effect on the flags. Any of these slips shows up in the read data or the interrupt outputs. A long random run compares both outputs every cycle against a behavioural model.

// File: rtl/chan_flag_status.sv
module chan_flag_status #(
  parameter int NUM_CH = 8,
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] REG_OFFSET = 'h50
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [NUM_CH-1:0] chan_event,
  input  logic [NUM_CH-1:0] irq_en,
  output logic [NUM_CH-1:0] irq_req
);
  logic [NUM_CH-1:0] flags, armed;
  logic hit, rd_hit, wr_hit;

  assign hit    = (bus_addr == REG_OFFSET);
  assign rd_hit = hit && bus_rd;
  assign wr_hit = hit && bus_wr;

  assign bus_rdata = rd_hit ? {{(32-NUM_CH){1'b0}}, flags} : 32'd0;
  assign irq_req   = flags & irq_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags <= '0;
      armed <= '0;
    end else begin
      for (int n = 0; n < NUM_CH; n++) begin
        if (chan_event[n]) begin
          flags[n] <= 1'b1;
          armed[n] <= 1'b0;
        end else if (wr_hit) begin
          if (armed[n] && !bus_wdata[n]) flags[n] <= 1'b0;
          armed[n] <= 1'b0;
        end else if (rd_hit && flags[n]) begin
          armed[n] <= 1'b1;
        end
      end
    end
  end

  // R2, R8: every event is visible in the flags on the next cycle
  a_r2_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (|chan_event) |=> ((flags & $past(chan_event)) == $past(chan_event)));

  // R4, R6: a flag can only fall if it was armed
  a_r6_clear_needs_arm: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(flags) & ~flags & ~$past(armed)) == '0));

  // R10: flags are steady without a write at the register offset
  a_r10_no_write_no_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_hit |=> ((flags & $past(flags)) == $past(flags)));

  // R2: no flag rises without its event
  a_r2_no_spurious_set: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flags & ~$past(flags) & ~$past(chan_event)) == '0));

  // R3: reserved read bits stay zero
  a_r3_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata[31:NUM_CH] == '0);
endmodule

// File: tb/test_chan_flag_status.sv
module test_chan_flag_status;
  localparam int NCH = 8;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] bus_addr = '0;
  logic bus_rd = 1'b0, bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [NCH-1:0] chan_event = '0, irq_en = '0, irq_req;

  chan_flag_status i_chan_flag_status (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .chan_event(chan_event), .irq_en(irq_en), .irq_req(irq_req));

  always #2 clk = ~clk;

  int compared = 0, mismatched = 0, cyc = 0;
  bit mf [NCH];
  bit ma [NCH];

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      mismatched++;
      $display("FAIL watchdog: actual hung, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  function automatic logic [31:0] model_flags();
    logic [31:0] v = '0;
    for (int n = 0; n < NCH; n++) v[n] = mf[n];
    return v;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(string tag, bit rd, bit wr, logic [7:0] addr,
                      logic [31:0] wd, logic [NCH-1:0] ev, logic [NCH-1:0] en);
    bit rh, wh;
    @(negedge clk);
    bus_rd = rd; bus_wr = wr; bus_addr = addr; bus_wdata = wd;
    chan_event = ev; irq_en = en;
    #1;
    rh = rd && addr == 8'h50;
    wh = wr && addr == 8'h50;
    check(tag, bus_rdata, rh ? model_flags() : 32'd0);
    check("R9", {24'd0, irq_req}, model_flags() & {24'd0, en});
    @(posedge clk);
    for (int n = 0; n < NCH; n++) begin
      if (ev[n]) begin mf[n] = 1; ma[n] = 0; end
      else if (wh) begin
        if (ma[n] && !wd[n]) mf[n] = 0;
        ma[n] = 0;
      end else if (rh && mf[n]) ma[n] = 1;
    end
  endtask

  task automatic idle(string tag);
    step(tag, 0, 0, 8'h00, 0, 0, 8'hFF);
  endtask

  task automatic rd_reg(string tag);
    step(tag, 1, 0, 8'h50, 0, 0, 8'hFF);
  endtask

  initial begin
    for (int n = 0; n < NCH; n++) begin mf[n] = 0; ma[n] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    rd_reg("R1");
    idle("R1");
    step("R2", 0, 0, 8'h00, 0, 8'b1010_0101, 8'hFF);
    rd_reg("R3");
    step("R4", 0, 1, 8'h50, 32'hFFFF_FF00, 0, 8'hFF);
    rd_reg("R4");
    step("R2", 0, 0, 8'h00, 0, 8'hFF, 8'hFF);
    step("R5", 0, 1, 8'h50, 32'hFFFF_FFFF, 0, 8'hFF);
    rd_reg("R5");
    step("R6", 0, 1, 8'h50, 32'h0, 0, 8'hFF);
    rd_reg("R6");
    rd_reg("R6");
    step("R6", 0, 1, 8'h50, 32'h0000_000F, 0, 8'hFF);
    step("R6", 0, 1, 8'h50, 32'h0, 0, 8'hFF);
    rd_reg("R6");
    rd_reg("R7");
    step("R7", 0, 0, 8'h00, 0, 8'b0000_0011, 8'hFF);
    step("R7", 0, 1, 8'h50, 32'h0, 0, 8'hFF);
    rd_reg("R7");
    rd_reg("R8");
    step("R8", 0, 1, 8'h50, 32'h0, 8'b0000_0001, 8'hFF);
    rd_reg("R8");
    step("R10", 1, 0, 8'h54, 0, 0, 8'hFF);
    rd_reg("R10");
    step("R10", 0, 1, 8'h4C, 32'h0, 0, 8'hFF);
    step("R10", 1, 0, 8'h51, 0, 0, 8'hFF);
    step("R10", 0, 1, 8'h50, 32'h0, 0, 8'hFF);
    rd_reg("R10");
    step("R9", 0, 0, 8'h00, 0, 0, 8'h5A);
    step("R9", 0, 0, 8'h00, 0, 0, 8'h00);
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] r = $urandom;
      step("R7", r[0] & r[1], r[2] & r[3], r[4] ? 8'h50 : 8'h44,
           {$urandom} & {24'hFF_FFFF, {8{r[5]}}},
           (r[6] & r[7]) ? r[15:8] : 8'h00, r[23:16]);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule